// File: doc/BRIEF.md
# Paged EEPROM Access Controller

This block sits behind a byte-level serial-slave front end and owns a 256-byte non-volatile array. The front end reports bus START and STOP events, hands over every received byte, and raises a read request whenever the host wants the next data byte. The block returns an acknowledge decision for every received byte and the data for every read request.

A write transaction names a byte address and then streams data bytes. These are collected in a one-page staging buffer. The low four address bits advance within the page and wrap back to its start, so later bytes overwrite earlier ones. When STOP arrives, the staged bytes are committed to the array. A timed busy period follows, and during it the block refuses its device address, so the host can poll for completion. Reads stream from the byte address counter and wrap across the whole array.

A protect input keeps the lower half of the array from being written. Bytes aimed there are still acknowledged but are dropped. If nothing was kept, no busy period starts.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: Every received byte (`rx_valid_i` high) produces `ack_valid_o` high exactly one cycle later, carrying the decision in `ack_o` (1 = ACK, 0 = NACK).
- R2: A device-address byte is the first byte after a START. Bits [7:4] must be 4'b1010, bits [3:1] must equal `dev_sel_i`, and bit 0 selects read (1) or write (0). A mismatched address is NACKed, and so is every byte after it until the next START.
- R3: After reset every array byte reads 0xFF and the byte address counter is 0.
- R4: A STOP that ends a write with at least one kept data byte starts a busy period of `BUSY_CYCLES` cycles. During that period a matching device address is NACKed. Afterwards it is ACKed again.
- R5: In a read transaction, `rd_data_o` with `rd_valid_o` arrives one cycle after `rd_req_i`. The data comes from the counter's current address, after which the counter increments by one and wraps from 0xFF to 0x00.
- R6: The byte after a write device address loads the address counter and is ACKed. Each data byte is ACKed and staged at the counter's address. After each data byte only the low 4 bits increment, so the counter wraps within the 16-byte page and later bytes overwrite earlier ones.
- R7: Staged bytes reach the array only on STOP. A START discards any staged bytes.
- R8: A write that carries an address byte but no data, followed by a repeated START and a read address, begins reading at that address.
- R9: While `wp_i` is high, data bytes aimed at addresses 0x00 to 0x7F are ACKed but discarded. If every staged byte was discarded, the STOP starts no busy period.
- R10: A STOP after a write with no data bytes starts no busy period.
- R11: Out of reset, `ack_valid_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START or repeated START seen on the bus (one-cycle pulse) |
| stop_i | input | 1 | STOP seen on the bus (one-cycle pulse) |
| rx_valid_i | input | 1 | A byte from the host is present on `rx_byte_i` |
| rx_byte_i | input | 8 | Byte received from the host |
| rd_req_i | input | 1 | Host wants the next read byte |
| wp_i | input | 1 | Protect the lower half of the array from writes |
| dev_sel_i | input | 3 | Device select bits compared against address bits [3:1] |
| ack_valid_o | output | 1 | Acknowledge decision is valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| rd_valid_o | output | 1 | Read data is valid |
| rd_data_o | output | 8 | Read data byte |

## Verification
Both acknowledge and read data come from registers. An acknowledge is therefore due on the first clock edge after its received byte, and read data on the first edge after its request. The driver pushes each expected value when it applies the stimulus at a falling edge. The monitor pops and compares on the following falling edge, the first one after the responding rising edge. The busy window is a whole run of cycles, not a single result. It is checked with a device-address probe a few cycles after STOP, which must be NACKed, and a second probe more than `BUSY_CYCLES` cycles later, which must be ACKed. Writes are confirmed only through later reads at the ports.

// File: rtl/eep_pkg.sv
package eep_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADDR,
      ST_WDATA,
      ST_READ,
      ST_SKIP
   } eep_state_e;

   function automatic logic dev_hit(input logic [BYTE_W-1:0] b,
                                    input logic [3:0] pre,
                                    input logic [2:0] sel);
      return (b[7:4] == pre) && (b[3:1] == sel);
   endfunction

endpackage

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
   parameter int PAGE_W = 4,
   parameter int BYTE_W = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  clr_i,
   input  logic                                  wr_i,
   input  logic [PAGE_W-1:0]                     lane_i,
   input  logic [BYTE_W-1:0]                     data_i,
   output logic [(1<<PAGE_W)-1:0][BYTE_W-1:0]    data_o,
   output logic [(1<<PAGE_W)-1:0]                valid_o
);
   localparam int LANES = 1 << PAGE_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic hit;
      assign hit = wr_i && (lane_i == PAGE_W'(l));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_o[l]  <= '0;
            valid_o[l] <= 1'b0;
         end else if (clr_i) begin
            valid_o[l] <= 1'b0;
         end else if (hit) begin
            data_o[l]  <= data_i;
            valid_o[l] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4,
   parameter int BYTE_W = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  commit_i,
   input  logic [ADDR_W-PAGE_W-1:0]              page_i,
   input  logic [(1<<PAGE_W)-1:0][BYTE_W-1:0]    data_i,
   input  logic [(1<<PAGE_W)-1:0]                valid_i,
   input  logic [ADDR_W-1:0]                     rd_addr_i,
   output logic [BYTE_W-1:0]                     rd_data_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int LANES = 1 << PAGE_W;

   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (commit_i) begin
         for (int l = 0; l < LANES; l++) begin
            if (valid_i[l]) mem[{page_i, PAGE_W'(l)}] <= data_i[l];
         end
      end
   end

   assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
   parameter int BUSY_CYCLES = 625000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);
   if (BUSY_CYCLES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_o <= 1'b0;
         else        busy_o <= load_i;
      end
   end else begin : g_count
      localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (load_i)     cnt <= CNT_W'(BUSY_CYCLES);
         else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign busy_o = (cnt != '0);
   end

endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
   import eep_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_W      = 4,
   parameter int         BUSY_CYCLES = 625000,
   parameter logic [3:0] PREAMBLE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_byte_i,
   input  logic              rd_req_i,
   input  logic              wp_i,
   input  logic [2:0]        dev_sel_i,
   output logic              ack_valid_o,
   output logic              ack_o,
   output logic              rd_valid_o,
   output logic [7:0]        rd_data_o
);
   localparam int LANES = 1 << PAGE_W;
   localparam int PG_W  = ADDR_W - PAGE_W;

   if (ADDR_W != 8) begin : g_bad_addr
      $error("ADDR_W must be 8 so the address byte fills the counter");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must lie between 1 and ADDR_W-1");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end

   eep_state_e               state;
   logic [ADDR_W-1:0]        addr_q;
   logic                     busy;
   logic                     st_dev, st_rd, st_wdata;
   logic                     byte_ev, prot, stage_wr, buf_any, commit;
   logic [LANES-1:0][7:0]    buf_data;
   logic [LANES-1:0]         buf_valid;
   logic [7:0]               arr_rd;

   assign st_dev   = (state == ST_DEV);
   assign st_rd    = (state == ST_READ);
   assign st_wdata = (state == ST_WDATA);
   assign byte_ev  = rx_valid_i && !start_i && !stop_i;
   assign prot     = wp_i && !addr_q[ADDR_W-1];
   assign stage_wr = byte_ev && st_wdata && !prot;
   assign buf_any  = |buf_valid;
   assign commit   = stop_i && buf_any && !busy;

   eep_page_buf #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) i_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (start_i || stop_i),
      .wr_i    (stage_wr),
      .lane_i  (addr_q[PAGE_W-1:0]),
      .data_i  (rx_byte_i),
      .data_o  (buf_data),
      .valid_o (buf_valid)
   );

   eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) i_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit_i  (commit),
      .page_i    (addr_q[ADDR_W-1:PAGE_W]),
      .data_i    (buf_data),
      .valid_i   (buf_valid),
      .rd_addr_i (addr_q),
      .rd_data_o (arr_rd)
   );

   eep_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (commit),
      .busy_o (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         addr_q      <= '0;
         ack_valid_o <= 1'b0;
         ack_o       <= 1'b0;
         rd_valid_o  <= 1'b0;
         rd_data_o   <= '0;
      end else begin
         ack_valid_o <= 1'b0;
         rd_valid_o  <= 1'b0;
         if (start_i) begin
            state <= ST_DEV;
         end else if (stop_i) begin
            state <= ST_IDLE;
         end else if (rx_valid_i) begin
            ack_valid_o <= 1'b1;
            ack_o       <= 1'b0;
            case (state)
               ST_DEV: begin
                  if (dev_hit(rx_byte_i, PREAMBLE, dev_sel_i) && !busy) begin
                     ack_o <= 1'b1;
                     state <= rx_byte_i[0] ? ST_READ : ST_WADDR;
                  end else begin
                     state <= ST_SKIP;
                  end
               end
               ST_WADDR: begin
                  ack_o  <= 1'b1;
                  addr_q <= rx_byte_i;
                  state  <= ST_WDATA;
               end
               ST_WDATA: begin
                  ack_o  <= 1'b1;
                  addr_q <= {addr_q[ADDR_W-1:PAGE_W],
                             PAGE_W'(addr_q[PAGE_W-1:0] + 1'b1)};
               end
               default: ack_o <= 1'b0;
            endcase
         end else if (rd_req_i && st_rd) begin
            rd_valid_o <= 1'b1;
            rd_data_o  <= arr_rd;
            addr_q     <= addr_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/eep_page_ctrl_chk.sv
module eep_page_ctrl_chk #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              stop_i,
   input logic              rx_valid_i,
   input logic              rd_req_i,
   input logic              ack_valid_o,
   input logic              ack_o,
   input logic              rd_valid_o,
   input logic              busy,
   input logic              st_dev,
   input logic              st_rd,
   input logic              st_wdata,
   input logic              buf_any,
   input logic [ADDR_W-1:0] addr_q
);
   assert_ack_follows_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_i && !start_i && !stop_i |=> ack_valid_o);

   assert_busy_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      st_dev && busy && rx_valid_i && !start_i && !stop_i |=> ack_valid_o && !ack_o);

   assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd && rd_req_i && !rx_valid_i && !start_i && !stop_i |=> rd_valid_o);

   assert_rd_incr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd && rd_req_i && !rx_valid_i && !start_i && !stop_i
      |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

   assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      st_wdata && rx_valid_i && !start_i && !stop_i
      |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));

   assert_no_empty_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i && !busy && !buf_any |=> !busy);

endmodule

bind eeprom_page_ctrl eep_page_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .stop_i      (stop_i),
   .rx_valid_i  (rx_valid_i),
   .rd_req_i    (rd_req_i),
   .ack_valid_o (ack_valid_o),
   .ack_o       (ack_o),
   .rd_valid_o  (rd_valid_o),
   .busy        (busy),
   .st_dev      (st_dev),
   .st_rd       (st_rd),
   .st_wdata    (st_wdata),
   .buf_any     (buf_any),
   .addr_q      (addr_q)
);

// File: tb/test_eeprom_page_ctrl.sv
module test_eeprom_page_ctrl;
   localparam int BUSY = 40;
   localparam logic [2:0] SEL = 3'b101;
   localparam logic [7:0] DEVW = {4'b1010, SEL, 1'b0};
   localparam logic [7:0] DEVR = {4'b1010, SEL, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 0, stop_i = 0, rx_valid_i = 0, rd_req_i = 0, wp_i = 0;
   logic [7:0] rx_byte_i = '0;
   logic ack_valid_o, ack_o, rd_valid_o;
   logic [7:0] rd_data_o;

   always #4 clk = ~clk;

   eeprom_page_ctrl #(.BUSY_CYCLES(BUSY)) i_eeprom_page_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .rd_req_i(rd_req_i),
      .wp_i(wp_i), .dev_sel_i(SEL), .ack_valid_o(ack_valid_o), .ack_o(ack_o),
      .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
   );

   int checks = 0;
   int fails = 0;
   bit    ack_q[$];
   string ack_tag[$];
   logic [7:0] rd_q[$];
   string rd_tag[$];

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (ack_valid_o) begin
            checks++;
            if (ack_q.size() == 0) begin
               fails++;
               $display("FAIL R1: unexpected ack actual %0d expected none", ack_o);
            end else begin
               automatic bit e = ack_q.pop_front();
               automatic string t = ack_tag.pop_front();
               if (ack_o !== e) begin
                  fails++;
                  $display("FAIL %s: ack actual %0d expected %0d", t, ack_o, e);
               end
            end
         end
         if (rd_valid_o) begin
            checks++;
            if (rd_q.size() == 0) begin
               fails++;
               $display("FAIL R5: unexpected read data actual %h expected none", rd_data_o);
            end else begin
               automatic logic [7:0] e = rd_q.pop_front();
               automatic string t = rd_tag.pop_front();
               if (rd_data_o !== e) begin
                  fails++;
                  $display("FAIL %s: data actual %h expected %h", t, rd_data_o, e);
               end
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      start_i = 1'b1; @(negedge clk); start_i = 1'b0; @(negedge clk);
   endtask

   task automatic do_stop();
      stop_i = 1'b1; @(negedge clk); stop_i = 1'b0; @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b, input bit ack, input string tag);
      ack_q.push_back(ack);
      ack_tag.push_back(tag);
      rx_byte_i = b; rx_valid_i = 1'b1;
      @(negedge clk);
      rx_valid_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] exp, input string tag);
      rd_q.push_back(exp);
      rd_tag.push_back(tag);
      rd_req_i = 1'b1;
      @(negedge clk);
      rd_req_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_read(input logic [7:0] a, input string tag);
      do_start();
      send(DEVW, 1'b1, tag);
      send(a, 1'b1, tag);
      do_start();
      send(DEVR, 1'b1, tag);
   endtask

   task automatic wait_write_done();
      do_start();
      send(DEVW, 1'b0, "R4 nack while busy");
      do_stop();
      idle(BUSY + 5);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run actual hung expected finished");
      report();
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      checks++;
      if (ack_valid_o !== 1'b0 || rd_valid_o !== 1'b0) begin
         fails++;
         $display("FAIL R11: valids actual %b%b expected 00", ack_valid_o, rd_valid_o);
      end

      // R3: immediate read from address 0 after reset, erased contents
      do_start();
      send(DEVR, 1'b1, "R2 read address");
      rd(8'hFF, "R3 erased byte 0");
      rd(8'hFF, "R3 erased byte 1");
      do_stop();

      // R6/R4/R8: write two bytes at 0x00, busy poll, selective read
      do_start();
      send(DEVW, 1'b1, "R2 write address");
      send(8'h00, 1'b1, "R6 address byte");
      send(8'h11, 1'b1, "R6 data byte");
      send(8'h22, 1'b1, "R6 data byte");
      do_stop();
      wait_write_done();
      set_read(8'h00, "R8 selective read");
      rd(8'h11, "R8 data at start address");
      rd(8'h22, "R6 second byte");
      do_stop();

      // R6: page wrap 0x7E,0x7F,0x70,0x71
      do_start();
      send(DEVW, 1'b1, "R6");
      send(8'h7E, 1'b1, "R6");
      send(8'hA1, 1'b1, "R6"); send(8'hA2, 1'b1, "R6");
      send(8'hA3, 1'b1, "R6"); send(8'hA4, 1'b1, "R6");
      do_stop();
      wait_write_done();
      set_read(8'h7E, "R5");
      rd(8'hA1, "R6 byte 0x7E");
      rd(8'hA2, "R6 byte 0x7F");
      rd(8'hFF, "R5 read crosses page to 0x80");
      do_stop();
      set_read(8'h70, "R6");
      rd(8'hA3, "R6 wrapped to 0x70");
      rd(8'hA4, "R6 wrapped to 0x71");
      rd(8'hFF, "R6 0x72 untouched");
      do_stop();

      // R6: 18 bytes overwrite the first two lanes
      do_start();
      send(DEVW, 1'b1, "R6");
      send(8'h90, 1'b1, "R6");
      for (int i = 0; i < 18; i++) send(8'h40 + 8'(i), 1'b1, "R6");
      do_stop();
      wait_write_done();
      set_read(8'h90, "R6");
      rd(8'h50, "R6 overwrite 0x90");
      rd(8'h51, "R6 overwrite 0x91");
      rd(8'h42, "R6 0x92 kept");
      do_stop();
      set_read(8'h9F, "R6");
      rd(8'h4F, "R6 last lane");
      do_stop();

      // R5: read wraps from 0xFF to 0x00, counter carries on
      do_start();
      send(DEVW, 1'b1, "R5"); send(8'hFF, 1'b1, "R5"); send(8'hEE, 1'b1, "R5");
      do_stop();
      wait_write_done();
      set_read(8'hFE, "R5");
      rd(8'hFF, "R5 0xFE");
      rd(8'hEE, "R5 0xFF");
      rd(8'h11, "R5 wrapped to 0x00");
      rd(8'h22, "R5 0x01");
      do_stop();
      do_start();
      send(DEVR, 1'b1, "R5");
      rd(8'hFF, "R5 immediate read continues at 0x02");
      do_stop();

      // R9: protected lower half
      wp_i = 1'b1;
      do_start();
      send(DEVW, 1'b1, "R9"); send(8'h05, 1'b1, "R9");
      send(8'h33, 1'b1, "R9 protected byte acked");
      send(8'h34, 1'b1, "R9 protected byte acked");
      do_stop();
      set_read(8'h05, "R9 no busy after protected write");
      rd(8'hFF, "R9 0x05 unchanged");
      rd(8'hFF, "R9 0x06 unchanged");
      do_stop();
      do_start();
      send(DEVW, 1'b1, "R9"); send(8'h85, 1'b1, "R9"); send(8'h66, 1'b1, "R9");
      do_stop();
      wait_write_done();
      wp_i = 1'b0;
      set_read(8'h85, "R9");
      rd(8'h66, "R9 upper half written");
      do_stop();

      // R10: data-less write
      do_start();
      send(DEVW, 1'b1, "R10"); send(8'h40, 1'b1, "R10");
      do_stop();
      do_start();
      send(DEVW, 1'b1, "R10 no busy after empty write");
      do_stop();

      // R2: mismatched select and preamble
      do_start();
      send(8'hA2, 1'b0, "R2 wrong select");
      send(8'h10, 1'b0, "R2 byte after mismatch");
      send(8'h55, 1'b0, "R2 byte after mismatch");
      do_stop();
      do_start();
      send(8'h3A, 1'b0, "R2 wrong preamble");
      do_stop();
      set_read(8'h10, "R2 no busy after ignored write");
      rd(8'hFF, "R2 0x10 unchanged");
      do_stop();

      // R7: repeated START drops staged bytes
      do_start();
      send(DEVW, 1'b1, "R7"); send(8'h20, 1'b1, "R7"); send(8'h77, 1'b1, "R7");
      do_start();
      send(DEVR, 1'b1, "R7");
      rd(8'hFF, "R7 read after data at 0x21");
      do_stop();
      set_read(8'h20, "R7 no busy after discarded write");
      rd(8'hFF, "R7 0x20 not written");
      do_stop();

      idle(5);
      checks++;
      if (ack_q.size() != 0 || rd_q.size() != 0) begin
         fails++;
         $display("FAIL R1: pending results actual %0d expected 0", ack_q.size() + rd_q.size());
      end
      report();
      $finish;
   end

endmodule